// File: doc/BRIEF.md
# Host-to-PCI I/O Window Decoder

This block holds the pair of decode registers that describe one host-to-PCI I/O window and turns them into a window start address, a window length and a valid flag. The window is measured in 2 MB granules. A 15-bit base register supplies the start address. Its low seven bits and a 7-bit top register together set how many granules the window spans.

Two fixed regions of the CPU physical address space can never be reached through the window. These holes are 0x1E000000 up to but not including 0x1F100000, and 0x1FC00000 up to but not including 0x1FD00000. The decoder trims the window around them. It then compares every incoming 32-bit CPU address against the trimmed window and raises a hit flag for addresses the window claims. Software writes the two registers through a simple write port. Other logic uses the start, length and valid outputs to program a mapping, and uses the hit flag to steer accesses.

Top module: `iowin_decoder`

## Requirements
- R1: After a synchronous active-high reset the base register holds 0x080 and the top register holds 0x00F. The outputs then show a valid window starting at 0x10000000 with length 0x02000000.
- R2: A write with `wr_sel`=0 stores `wr_data[14:0]` into the base register. A write with `wr_sel`=1 stores `wr_data[6:0]` into the top register. All other data bits are discarded.
- R3: The window is valid only when base[6:0] is less than or equal to the top register. An invalid window shows `win_valid`=0 with start and length both 0.
- R4: Before trimming, the start address is the base register shifted left by 21 bits and truncated to 32 bits.
- R5: Before trimming, the length is (top + 1 − base[6:0]) shifted left by 21 bits.
- R6: If the start address lies inside a hole, the start moves to the first address above that hole.
- R7: If the window end (start + length) lies inside a hole, the end is pulled back to the first address of that hole.
- R8: If a hole would split the window, the window is reported invalid and no address hits it. A hole splits the window when the end is at or above the end of the hole and the start is below the beginning of the hole.
- R9: `hit` is 1 exactly when the window is valid and start ≤ `lookup_addr` < start + length. It follows `lookup_addr` combinationally.
- R10: Start, length and valid change exactly two clock edges after the edge that takes a register write: one edge loads the register and the next loads the outputs. Without writes the outputs hold.
- R11: If trimming leaves the end at or below the start, the window is reported invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the base register, 1 selects the top register |
| wr_data | input | 32 | Write data |
| lookup_addr | input | 32 | CPU physical address to test |
| win_valid | output | 1 | Trimmed window is usable |
| win_start | output | 32 | Trimmed window start address |
| win_len | output | 32 | Trimmed window length in bytes |
| hit | output | 1 | lookup_addr falls inside the trimmed window |

## Verification
The register stage and the output stage each add one edge, so a new start, length and valid are visible two edges after the write edge. The bench drives inputs on falling edges. The latency case samples once after the first edge, where it expects the old values, and once after the second edge, where it expects the new ones. Table rows wait two full edges after their last write before sampling. The hit flag has no register in its path, so it is checked 1 ns after `lookup_addr` changes, with no clock edge in between.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  localparam int ADDR_W  = 32;
  localparam int EXT_W   = ADDR_W + 1;
  localparam int N_HOLES = 2;

  typedef struct packed {
    logic [EXT_W-1:0] first;
    logic [EXT_W-1:0] past;   // first address above the hole
  } hole_t;

  // Holes in ascending order; trimming walks them in this order.
  localparam hole_t HOLES [N_HOLES] = '{
    '{first: 33'h0_1E00_0000, past: 33'h0_1F10_0000},
    '{first: 33'h0_1FC0_0000, past: 33'h0_1FD0_0000}
  };

  typedef struct packed {
    logic             ok;
    logic [EXT_W-1:0] lo;
    logic [EXT_W-1:0] hi;
  } span_t;

endpackage

// File: rtl/iowin_regs.sv
module iowin_regs #(
  parameter int DATA_W   = 32,
  parameter int BASE_W   = 15,
  parameter int TOP_W    = 7,
  parameter logic [BASE_W-1:0] RST_BASE = 15'h080,
  parameter logic [TOP_W-1:0]  RST_TOP  = 7'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BASE_W-1:0] base_q,
  output logic [TOP_W-1:0]  top_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= RST_BASE;
      top_q  <= RST_TOP;
    end else if (wr_en) begin
      if (wr_sel) top_q  <= wr_data[TOP_W-1:0];
      else        base_q <= wr_data[BASE_W-1:0];
    end
  end

endmodule

// File: rtl/iowin_span.sv
module iowin_span
  import iowin_pkg::*;
#(
  parameter int BASE_W     = 15,
  parameter int TOP_W      = 7,
  parameter int GRAN_SHIFT = 21
) (
  input  logic [BASE_W-1:0] base_q,
  input  logic [TOP_W-1:0]  top_q,
  output span_t             raw
);

  localparam int WIDE_W = BASE_W + GRAN_SHIFT;
  localparam int CNT_W  = TOP_W + 1;

  logic [WIDE_W-1:0] base_wide;
  logic [CNT_W-1:0]  granules;
  logic [EXT_W-1:0]  byte_len;
  logic [EXT_W-1:0]  lo_addr;

  always_comb begin
    base_wide = {base_q, {GRAN_SHIFT{1'b0}}};
    lo_addr   = {1'b0, base_wide[ADDR_W-1:0]};
    granules  = {1'b0, top_q} + CNT_W'(1) - {1'b0, base_q[TOP_W-1:0]};
    byte_len  = EXT_W'(granules) << GRAN_SHIFT;
    raw.ok    = (base_q[TOP_W-1:0] <= top_q);
    raw.lo    = lo_addr;
    raw.hi    = lo_addr + byte_len;
  end

endmodule

// File: rtl/iowin_trim.sv
module iowin_trim
  import iowin_pkg::*;
(
  input  span_t raw,
  output span_t trimmed
);

  span_t stage [N_HOLES+1];

  assign stage[0] = raw;

  for (genvar g = 0; g < N_HOLES; g++) begin : g_hole
    logic [EXT_W-1:0] hi_c, lo_c;
    logic             split;
    always_comb begin
      hi_c = stage[g].hi;
      lo_c = stage[g].lo;
      if (hi_c >= HOLES[g].first && hi_c < HOLES[g].past) hi_c = HOLES[g].first;
      if (lo_c >= HOLES[g].first && lo_c < HOLES[g].past) lo_c = HOLES[g].past;
      split = (hi_c >= HOLES[g].past) && (lo_c < HOLES[g].first);
      stage[g+1].ok = stage[g].ok && !split;
      stage[g+1].lo = lo_c;
      stage[g+1].hi = hi_c;
    end
  end

  always_comb begin
    trimmed    = stage[N_HOLES];
    trimmed.ok = stage[N_HOLES].ok && (stage[N_HOLES].hi > stage[N_HOLES].lo);
  end

endmodule

// File: rtl/iowin_match.sv
module iowin_match
  import iowin_pkg::*;
(
  input  logic              valid,
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0] len,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  logic [EXT_W-1:0] limit;

  always_comb begin
    limit = {1'b0, start} + {1'b0, len};
    hit   = valid && (addr >= start) && ({1'b0, addr} < limit);
  end

endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
  import iowin_pkg::*;
#(
  parameter int BASE_W     = 15,
  parameter int TOP_W      = 7,
  parameter int GRAN_SHIFT = 21,
  parameter logic [BASE_W-1:0] RST_BASE = 15'h080,
  parameter logic [TOP_W-1:0]  RST_TOP  = 7'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       lookup_addr,
  output logic              win_valid,
  output logic [31:0]       win_start,
  output logic [31:0]       win_len,
  output logic              hit
);

  logic [BASE_W-1:0] base_q;
  logic [TOP_W-1:0]  top_q;
  span_t             raw, trimmed;
  logic [EXT_W-1:0]  span_bytes;

  iowin_regs #(
    .DATA_W(ADDR_W), .BASE_W(BASE_W), .TOP_W(TOP_W),
    .RST_BASE(RST_BASE), .RST_TOP(RST_TOP)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .base_q(base_q), .top_q(top_q)
  );

  iowin_span #(.BASE_W(BASE_W), .TOP_W(TOP_W), .GRAN_SHIFT(GRAN_SHIFT)) u_span (
    .base_q(base_q), .top_q(top_q), .raw(raw)
  );

  iowin_trim u_trim (.raw(raw), .trimmed(trimmed));

  assign span_bytes = trimmed.hi - trimmed.lo;

  // Output stage: loaded from the decode of the register stage. Reset is
  // held for at least two edges, so these settle to the reset window.
  always_ff @(posedge clk) begin
    win_valid <= trimmed.ok;
    win_start <= trimmed.ok ? trimmed.lo[ADDR_W-1:0] : '0;
    win_len   <= trimmed.ok ? span_bytes[ADDR_W-1:0] : '0;
  end

  iowin_match u_match (
    .valid(win_valid), .start(win_start), .len(win_len),
    .addr(lookup_addr), .hit(hit)
  );

endmodule

// File: rtl/iowin_checker.sv
module iowin_checker
  import iowin_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] lookup_addr,
  input logic        win_valid,
  input logic [31:0] win_start,
  input logic [31:0] win_len,
  input logic        hit
);

  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
    !win_valid |-> (win_start == 32'h0 && win_len == 32'h0)); // R3

  AST_VALID_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (win_len != 32'h0)); // R11

  AST_HIT_INSIDE: assert property (@(posedge clk) disable iff (rst)
    hit |-> (win_valid && lookup_addr >= win_start
             && (lookup_addr - win_start) < win_len)); // R9

  AST_HIT_NOT_HOLE0: assert property (@(posedge clk) disable iff (rst)
    hit |-> !({1'b0, lookup_addr} >= HOLES[0].first
              && {1'b0, lookup_addr} < HOLES[0].past)); // R8

  AST_HIT_NOT_HOLE1: assert property (@(posedge clk) disable iff (rst)
    hit |-> !({1'b0, lookup_addr} >= HOLES[1].first
              && {1'b0, lookup_addr} < HOLES[1].past)); // R8

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !$past(wr_en)) |=>
      ($stable(win_valid) && $stable(win_start) && $stable(win_len))); // R10

endmodule

bind iowin_decoder iowin_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .lookup_addr(lookup_addr),
  .win_valid(win_valid), .win_start(win_start), .win_len(win_len), .hit(hit)
);

// File: tb/iowin_decoder_test.sv
module iowin_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] lookup_addr = '0;
  logic        win_valid, hit;
  logic [31:0] win_start, win_len;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  iowin_decoder uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .lookup_addr(lookup_addr), .win_valid(win_valid), .win_start(win_start),
    .win_len(win_len), .hit(hit)
  );

  typedef struct packed {
    logic [31:0] base_w;
    logic [31:0] top_w;
    logic        v;
    logic [31:0] s;
    logic [31:0] l;
    logic [31:0] probe;
    logic        probe_hit;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h001,      32'h003,      1'b1, 32'h0020_0000, 32'h0060_0000, 32'h007F_FFFF, 1'b1, 8'd4},  // R4
    '{32'hFFFF_8001,32'hFFFF_FF83,1'b1, 32'h0020_0000, 32'h0060_0000, 32'h0080_0000, 1'b0, 8'd2},  // R2
    '{32'h005,      32'h004,      1'b0, 32'h0,         32'h0,         32'h00A0_0000, 1'b0, 8'd3},  // R3
    '{32'h000,      32'h07F,      1'b1, 32'h0,         32'h1000_0000, 32'h0FFF_FFFF, 1'b1, 8'd5},  // R5
    '{32'h0F0,      32'h071,      1'b0, 32'h0,         32'h0,         32'h1E10_0000, 1'b0, 8'd11}, // R11
    '{32'h0F0,      32'h078,      1'b1, 32'h1F10_0000, 32'h0010_0000, 32'h1F0F_FFFF, 1'b0, 8'd6},  // R6
    '{32'h0E8,      32'h070,      1'b1, 32'h1D00_0000, 32'h0100_0000, 32'h1E00_0000, 1'b0, 8'd7},  // R7
    '{32'h0E8,      32'h07F,      1'b0, 32'h0,         32'h0,         32'h1D00_0000, 1'b0, 8'd8},  // R8
    '{32'h0F8,      32'h07D,      1'b1, 32'h1F10_0000, 32'h00B0_0000, 32'h1FBF_FFFF, 1'b1, 8'd7},  // R7
    '{32'h0FE,      32'h07F,      1'b1, 32'h1FD0_0000, 32'h0030_0000, 32'h1FD0_0000, 1'b1, 8'd6},  // R6
    '{32'h7FFF,     32'h07F,      1'b1, 32'hFFE0_0000, 32'h0020_0000, 32'hFFFF_FFFF, 1'b1, 8'd4}   // R4
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic exp);
    lookup_addr = a;
    #1;
    check(req, "hit", {31'b0, hit}, {31'b0, exp});
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset window
    check("R1", "valid", {31'b0, win_valid}, 32'h1);
    check("R1", "start", win_start, 32'h1000_0000);
    check("R1", "len",   win_len,   32'h0200_0000);
    // R9 boundaries of reset window, combinational
    probe("R9", 32'h1000_0000, 1'b1);
    probe("R9", 32'h11FF_FFFF, 1'b1);
    probe("R9", 32'h1200_0000, 1'b0);
    probe("R9", 32'h0FFF_FFFF, 1'b0);

    // R10 latency: one edge after the write edge the old value remains
    wr(1'b1, 32'h0000_001F);
    check("R10", "len after 1 edge", win_len, 32'h0200_0000);
    @(negedge clk);
    check("R10", "len after 2 edges", win_len, 32'h0400_0000);
    repeat (3) @(negedge clk);
    check("R10", "len held", win_len, 32'h0400_0000);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      wr(1'b0, VECS[i].base_w);
      wr(1'b1, VECS[i].top_w);
      @(negedge clk);
      check(tag, "valid", {31'b0, win_valid}, {31'b0, VECS[i].v});
      check(tag, "start", win_start, VECS[i].s);
      check(tag, "len",   win_len,   VECS[i].l);
      probe(tag, VECS[i].probe, VECS[i].probe_hit);
    end

    // R8: split window never hits, on either side of the hole
    wr(1'b0, 32'h0E8);
    wr(1'b1, 32'h07F);
    @(negedge clk);
    probe("R8", 32'h1F80_0000, 1'b0);
    // R6: clipped start; first byte above the hole hits
    wr(1'b1, 32'h070);
    wr(1'b0, 32'h0F0);
    wr(1'b1, 32'h078);
    @(negedge clk);
    probe("R6", 32'h1F10_0000, 1'b1);
    probe("R6", 32'h1F1F_FFFF, 1'b1);
    probe("R6", 32'h1F20_0000, 1'b0);

    // R1 again: reset restores the default window
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "start after re-reset", win_start, 32'h1000_0000);
    check("R1", "len after re-reset",   win_len,   32'h0200_0000);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule